// File: doc/BRIEF.md
# Serial Memory Slave Access Controller

This block sits behind a two-wire serial bus as a slave and gives the bus master access to a 256-byte array held outside the block. It oversamples the clock and data lines on its own system clock. It detects bus start and stop conditions and decodes the seven-bit device identifier plus direction bit that opens every transfer. It acknowledges the bytes it accepts by pulling the data line low through an open-drain enable. Writes go to the array through a registered single-cycle write strobe. Reads come back through a synchronous read port that has one cycle of latency.

An internal byte pointer selects the array location. A write transfer loads the pointer with its first byte. After that, each data byte is written at the pointer, and the pointer steps inside its 16-byte page. A read transfer returns the byte at the pointer and moves the pointer on by one across the whole array. The master keeps a read going by acknowledging each byte. A random read is a write of the address alone, followed by a repeated start and a read.

Two more identifiers name small auxiliary targets. Their bytes are acknowledged and have no further effect, except that any access to them sets a lock. While the lock is set, the controller refuses a plain current-pointer read. Only a random read is accepted, and that random read clears the lock.

Top module: `eep_slave_ctrl`

## Requirements
- R1: A falling data line while the clock is high is a start condition. It makes the next eight clocked bits an identifier byte, including when it arrives in the middle of a transfer (repeated start). A rising data line while the clock is high is a stop condition, and it returns the block to idle.
- R2: The identifier byte is received MSB first: seven identifier bits, then the direction bit (1 = read). Identifier 1010000 selects the array, and identifiers 1010111 and 1010010 select the auxiliary targets. These are acknowledged by driving the data line low for the ninth clock. Any other identifier is not acknowledged, and the block keeps the line released.
- R3: In a write to the array, the first byte after the identifier loads the pointer. Each following byte is acknowledged and written to the pointer location with a write strobe that lasts exactly one system clock.
- R4: During writes, only the low 4 pointer bits advance, wrapping from 15 to 0 with the upper bits kept. For example, 12 bytes starting at 0x3B go to 0x3B..0x3F and then 0x30..0x36, and the pointer is left at 0x37.
- R5: An accepted read returns the byte at the pointer, MSB first, and leaves the pointer one higher. A read from location n is therefore followed by a current read of n+1.
- R6: A low data line on the ninth clock of a read byte (master acknowledge) starts the next byte at the following location. The pointer wraps from 0xFF to 0x00.
- R7: A high data line on the ninth clock of a read byte ends the read. The block then drives nothing until the next start condition.
- R8: Any access to an auxiliary target sets the lock output. Auxiliary write bytes are acknowledged but cause no array write. Auxiliary reads return 0x00.
- R9: While the lock is set, a read to the array that does not directly follow an address-only write and repeated start is not acknowledged. A random read is accepted and clears the lock, after which current reads are acknowledged again.
- R10: The data-line drive changes only while the clock line is low. Incoming bits are taken on clock rising edges.
- R11: During reset the data line is released, the write strobe is low, the lock is clear and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Pull data line low when 1 |
| mem_addr | output | AW (8) | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write strobe, one clock |
| mem_rdata | input | 8 | Array read data, one clock after the address |
| cur_rd_locked | output | 1 | Current-pointer reads are refused while 1 |

## Verification
In a page write that crosses a page boundary, the array write strobe and the pointer wrap land on the same system clock. A 12-byte write from 0x3B provokes this. The strobed addresses are compared against an expected-write queue on every clock, and a current read afterwards shows where the pointer ended. Acceptance of a random read and release of the lock also share one decision. This is provoked by locking through an auxiliary access, trying a refused current read, and then judging both the acknowledge and the lock output after the random read.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_WADDR,
    S_WDATA,
    S_RDATA
  } eep_st_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_CNT_W = 4;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_smp
);
  logic [SYNC:0] scl_sh;
  logic [SYNC:0] sda_sh;
  logic scl_cur, scl_prev, sda_cur, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC-1:0], sda_i};
    end
  end

  assign scl_cur  = scl_sh[SYNC-1];
  assign scl_prev = scl_sh[SYNC];
  assign sda_cur  = sda_sh[SYNC-1];
  assign sda_prev = sda_sh[SYNC];

  assign scl_rise  = scl_cur & ~scl_prev;
  assign scl_fall  = ~scl_cur & scl_prev;
  assign start_det = scl_cur & scl_prev & sda_prev & ~sda_cur;
  assign stop_det  = scl_cur & scl_prev & ~sda_prev & sda_cur;
  assign sda_smp   = sda_cur;
endmodule

// File: rtl/eep_ptr.sv
module eep_ptr #(
  parameter int unsigned AW = 8,
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc_pg,
  input  logic          inc_all,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q, ptr_n;
  logic [PW-1:0] low_inc;

  assign low_inc = ptr_q[PW-1:0] + 1'b1;

  always_comb begin
    ptr_n = ptr_q;
    if (ld)           ptr_n = ld_val;
    else if (inc_pg)  ptr_n = {ptr_q[AW-1:PW], low_inc};
    else if (inc_all) ptr_n = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ptr_q <= '0;
    else if (ld | inc_pg | inc_all) ptr_q <= ptr_n;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/eep_slave_ctrl.sv
module eep_slave_ctrl #(
  parameter int unsigned AW     = 8,
  parameter int unsigned PW     = 4,
  parameter logic [6:0]  ID_MEM = 7'b1010000,
  parameter logic [6:0]  ID_POT = 7'b1010111,
  parameter logic [6:0]  ID_CFG = 7'b1010010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  input  logic [7:0]    mem_rdata,
  output logic          cur_rd_locked
);
  import eep_pkg::*;

  localparam logic [BIT_CNT_W-1:0] ACK_SLOT = BIT_CNT_W'(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic scl_rise, scl_fall, start_det, stop_det, sda_smp;

  i2c_line_cond #(.SYNC(2)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_smp(sda_smp)
  );

  eep_st_t st_q, st_n, nst_q, nst_n;
  logic [BIT_CNT_W-1:0] bcnt_q, bcnt_n;
  logic [7:0] shr_q, shr_n, tx_q, tx_n, rx_byte, wd_q;
  logic oe_q, oe_n, ackp_q, ackp_n, aux_q, aux_n, lock_q, lock_n, arm_q, arm_n;
  logic ld, inc_pg, inc_all, wr_evt, go_rd, we_q;
  logic [AW-1:0] ptr_q, ma_q;
  logic [6:0] id_f;
  logic rw_f, is_mem, is_aux;

  eep_ptr #(.AW(AW), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(AW'(rx_byte)),
    .inc_pg(inc_pg), .inc_all(inc_all), .ptr(ptr_q)
  );

  assign rx_byte = {shr_q[6:0], sda_smp};
  assign id_f    = rx_byte[7:1];
  assign rw_f    = rx_byte[0];
  assign is_mem  = (id_f == ID_MEM);
  assign is_aux  = (id_f == ID_POT) || (id_f == ID_CFG);

  always_comb begin
    st_n = st_q;  nst_n = nst_q; bcnt_n = bcnt_q; shr_n = shr_q; tx_n = tx_q;
    oe_n = oe_q;  ackp_n = ackp_q; aux_n = aux_q; lock_n = lock_q; arm_n = arm_q;
    ld = 1'b0; inc_pg = 1'b0; inc_all = 1'b0; wr_evt = 1'b0; go_rd = 1'b0;
    if (start_det) begin
      st_n = S_DEV;
      bcnt_n = '0;
    end else if (stop_det) begin
      st_n = S_IDLE;
      bcnt_n = '0;
      arm_n = 1'b0;
    end else if (scl_rise && st_q != S_IDLE) begin
      if (bcnt_q != ACK_SLOT) begin
        bcnt_n = bcnt_q + 1'b1;
        if (st_q != S_RDATA) begin
          shr_n = rx_byte;
          if (bcnt_q == LAST_BIT) begin
            ackp_n = 1'b1;
            case (st_q)
              S_DEV: begin
                arm_n = 1'b0;
                if (is_mem && !rw_f) begin
                  nst_n = S_WADDR; aux_n = 1'b0;
                end else if (is_mem) begin
                  aux_n = 1'b0;
                  if (lock_q && !arm_q) begin
                    ackp_n = 1'b0; nst_n = S_IDLE;
                  end else begin
                    nst_n = S_RDATA;
                    if (arm_q) lock_n = 1'b0;
                  end
                end else if (is_aux) begin
                  aux_n = 1'b1; lock_n = 1'b1;
                  nst_n = rw_f ? S_RDATA : S_WADDR;
                end else begin
                  ackp_n = 1'b0; nst_n = S_IDLE;
                end
              end
              S_WADDR: begin
                nst_n = S_WDATA;
                if (!aux_q) begin ld = 1'b1; arm_n = 1'b1; end
              end
              default: begin
                nst_n = S_WDATA;
                if (!aux_q) begin wr_evt = 1'b1; inc_pg = 1'b1; arm_n = 1'b0; end
              end
            endcase
          end
        end
      end else begin
        bcnt_n = '0;
        if (st_q == S_RDATA) begin
          go_rd = !sda_smp;
          if (sda_smp) st_n = S_IDLE;
        end else begin
          st_n  = nst_q;
          go_rd = (nst_q == S_RDATA);
        end
        if (go_rd) begin
          tx_n    = aux_q ? 8'h00 : mem_rdata;
          inc_all = !aux_q;
          st_n    = S_RDATA;
        end
      end
    end else if (scl_fall) begin
      if (st_q == S_RDATA && bcnt_q != ACK_SLOT)
        oe_n = ~tx_q[~bcnt_q[2:0]];
      else if (st_q != S_IDLE && st_q != S_RDATA && bcnt_q == ACK_SLOT)
        oe_n = ackp_q;
      else
        oe_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; nst_q <= S_IDLE; bcnt_q <= '0; shr_q <= '0; tx_q <= '0;
      oe_q <= 1'b0; ackp_q <= 1'b0; aux_q <= 1'b0; lock_q <= 1'b0; arm_q <= 1'b0;
    end else begin
      st_q <= st_n; nst_q <= nst_n; bcnt_q <= bcnt_n; shr_q <= shr_n; tx_q <= tx_n;
      oe_q <= oe_n; ackp_q <= ackp_n; aux_q <= aux_n; lock_q <= lock_n; arm_q <= arm_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0; wd_q <= '0; ma_q <= '0;
    end else begin
      we_q <= wr_evt;
      ma_q <= ptr_q;
      if (wr_evt) wd_q <= rx_byte;
    end
  end

  assign sda_oe        = oe_q;
  assign mem_addr      = ma_q;
  assign mem_wdata     = wd_q;
  assign mem_we        = we_q;
  assign cur_rd_locked = lock_q;
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] ptr,
  input logic          cur_rd_locked,
  input logic          arm
);
  // R10: drive changes only while the bus clock is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R3: write strobe lasts one clock
  p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R4: after a write the pointer sits one step further inside the same page
  p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ptr[AW-1:PW] == mem_addr[AW-1:PW]) &&
               (ptr[PW-1:0] == PW'(mem_addr[PW-1:0] + 1'b1)));

  // R9: the lock only drops when a random read was armed
  p_unlock_rand_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cur_rd_locked) |-> $past(arm));

  // R11: released line and idle strobe while in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r11: assert (!sda_oe && !mem_we && !cur_rd_locked);
    end
  end
endmodule

bind eep_slave_ctrl eep_slave_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .mem_we(mem_we),
  .mem_addr(mem_addr), .ptr(ptr_q), .cur_rd_locked(cur_rd_locked), .arm(arm_q)
);

// File: tb/eep_slave_ctrl_bench.sv
`timescale 1ns/1ps
module eep_slave_ctrl_bench;
  localparam int HP = 8;
  localparam logic [6:0] IDM = 7'b1010000;
  localparam logic [6:0] IDP = 7'b1010111;
  localparam logic [6:0] IDC = 7'b1010010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, mem_we, locked;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic sda_line;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  eep_slave_ctrl u_eep_slave_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .cur_rd_locked(locked)
  );

  logic [7:0] bmem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] wq[$];
  int n_chk = 0, n_err = 0, m_chk = 0, m_err = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;

  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr] <= mem_wdata;
    mem_rdata <= bmem[mem_addr];
  end

  // reference model of array writes and bus drive, compared every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        m_chk++;
        if (wq.size() == 0) begin
          m_err++;
          $display("FAIL R3 unexpected write act=%02h/%02h exp=none", mem_addr, mem_wdata);
        end else begin
          logic [15:0] e;
          e = wq.pop_front();
          if ({mem_addr, mem_wdata} !== e) begin
            m_err++;
            $display("FAIL R4 write act=%02h/%02h exp=%02h/%02h", mem_addr, mem_wdata, e[15:8], e[7:0]);
          end
        end
      end
      if (sda_oe !== prev_oe) begin
        m_chk++;
        if (scl_m) begin
          m_err++;
          $display("FAIL R10 drive changed with clock high act=%0b exp=%0b", sda_oe, prev_oe);
        end
      end
      prev_oe = sda_oe;
    end
  end

  task automatic hp();
    repeat (HP) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic exp_wr(logic [7:0] a, logic [7:0] d);
    wq.push_back({a, d});
    exp_mem[a] = d;
  endtask

  task automatic bstart();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic bstop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic wbyte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
    end
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
    ack = (sda_line == 1'b0);
    scl_m = 1'b0; hp();
  endtask

  task automatic rbyte(bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b1; hp(); b[i] = sda_line; scl_m = 1'b0; hp();
    end
    sda_m = mack ? 1'b0 : 1'b1; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
    sda_m = 1'b1;
  endtask

  task automatic rand_rd(logic [7:0] a, string tag);
    bit ack;
    bstart();
    wbyte({IDM, 1'b0}, ack); chk(ack, {tag, " dummy id ack"}, ack, 1);
    wbyte(a, ack);           chk(ack, {tag, " address ack"}, ack, 1);
    bstart();
    wbyte({IDM, 1'b1}, ack); chk(ack, {tag, " read id ack"}, ack, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk + m_chk, n_err + m_err);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (4) @(posedge clk); #1;
    chk(sda_oe == 1'b0, "R11 sda released in reset", sda_oe, 0);
    chk(mem_we == 1'b0, "R11 no write in reset", mem_we, 0);
    chk(locked == 1'b0, "R11 lock clear in reset", locked, 0);
    rst_n = 1'b1; hp();

    // R11: pointer starts at zero, current read returns location 0
    bstart(); wbyte({IDM, 1'b1}, ack); chk(ack, "R5 current read id ack", ack, 1);
    rbyte(1'b0, d); bstop();
    chk(d == exp_mem[0], "R11 pointer reset to zero", d, exp_mem[0]);

    // R3 byte write
    bstart();
    wbyte({IDM, 1'b0}, ack); chk(ack, "R2 memory id ack", ack, 1);
    wbyte(8'h20, ack);       chk(ack, "R3 address ack", ack, 1);
    exp_wr(8'h20, 8'hA5);
    wbyte(8'hA5, ack);       chk(ack, "R3 data ack", ack, 1);
    bstop();

    // R4 page write crossing the page end
    bstart();
    wbyte({IDM, 1'b0}, ack); wbyte(8'h3B, ack);
    for (int i = 0; i < 12; i++) begin
      exp_wr({4'h3, 4'(4'hB + i)}, 8'(8'hC0 + i));
      wbyte(8'(8'hC0 + i), ack);
      chk(ack, "R4 page data ack", ack, 1);
    end
    bstop();
    bstart(); wbyte({IDM, 1'b1}, ack); rbyte(1'b0, d); bstop();
    chk(d == exp_mem[8'h37], "R4 pointer left at 0x37", d, exp_mem[8'h37]);

    // R5 random read then current read of n+1
    rand_rd(8'h3B, "R5"); rbyte(1'b0, d); bstop();
    chk(d == 8'hC0, "R5 random read data", d, 8'hC0);
    bstart(); wbyte({IDM, 1'b1}, ack); rbyte(1'b0, d); bstop();
    chk(d == 8'hC1, "R5 current read of n+1", d, 8'hC1);

    // R6 sequential read across the array end, R7 release after nack
    rand_rd(8'hFE, "R6");
    rbyte(1'b1, d); chk(d == exp_mem[8'hFE], "R6 seq byte 0", d, exp_mem[8'hFE]);
    rbyte(1'b1, d); chk(d == exp_mem[8'hFF], "R6 seq byte 1", d, exp_mem[8'hFF]);
    rbyte(1'b0, d); chk(d == exp_mem[8'h00], "R6 seq wraps to 0", d, exp_mem[8'h00]);
    begin
      int low = 0;
      for (int i = 0; i < 9; i++) begin
        scl_m = 1'b1; hp(); if (sda_line == 1'b0) low++; scl_m = 1'b0; hp();
      end
      chk(low == 0, "R7 no drive after master nack", low, 0);
    end
    bstop();

    // R2 unknown identifier
    bstart(); wbyte({7'b1010001, 1'b0}, ack); bstop();
    chk(!ack, "R2 unknown id not acked", ack, 0);

    // R8 auxiliary write: acked, no array write, lock set
    bstart();
    wbyte({IDC, 1'b0}, ack); chk(ack, "R8 aux id ack", ack, 1);
    wbyte(8'h00, ack);       chk(ack, "R8 aux address ack", ack, 1);
    wbyte(8'h77, ack);       chk(ack, "R8 aux data ack", ack, 1);
    bstop();
    chk(locked == 1'b1, "R8 lock set by aux access", locked, 1);

    // R9 current read refused while locked
    bstart(); wbyte({IDM, 1'b1}, ack); bstop();
    chk(!ack, "R9 locked current read refused", ack, 0);

    // R8 auxiliary read returns zero
    bstart(); wbyte({IDP, 1'b1}, ack); chk(ack, "R8 aux read ack", ack, 1);
    rbyte(1'b0, d); bstop();
    chk(d == 8'h00, "R8 aux read data", d, 0);

    // R9 random read accepted and clears lock
    rand_rd(8'h20, "R9"); rbyte(1'b0, d); bstop();
    chk(d == 8'hA5, "R9 random read data while locked", d, 8'hA5);
    chk(locked == 1'b0, "R9 lock cleared", locked, 0);
    bstart(); wbyte({IDM, 1'b1}, ack); chk(ack, "R9 current read acked again", ack, 1);
    rbyte(1'b0, d); bstop();
    chk(d == exp_mem[8'h21], "R9 current read data", d, exp_mem[8'h21]);

    // R1 repeated start mid-transfer restarts decoding
    bstart();
    wbyte({IDM, 1'b0}, ack); wbyte(8'h44, ack);
    bstart();
    wbyte({IDM, 1'b0}, ack); chk(ack, "R1 id after repeated start ack", ack, 1);
    wbyte(8'h60, ack);
    exp_wr(8'h60, 8'h11);
    wbyte(8'h11, ack); bstop();
    rand_rd(8'h60, "R1"); rbyte(1'b0, d); bstop();
    chk(d == 8'h11, "R1 write after repeated start", d, 8'h11);

    hp(); hp();
    chk(wq.size() == 0, "R3 all expected writes seen", wq.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk + m_chk, n_err + m_err);
    $finish;
  end
endmodule